// File: doc/BRIEF.md
# Synchronous Glitch-Free Clock Stop Gate

This block sits between a clock synthesizer's divider outputs and the board pins. It turns a processor-side group of clocks and a bus-side group of clocks on and off without producing a shortened pulse. A stopped clock always rests at logic low. One further bus-side output follows the free-running reference clock. It is controlled by nothing but its own register bit.

Each gated output has a run request. The request is the AND of two things: the output's register enable bit, and the permission from its group's active-low stop pin. The stop pins count only when `mode` is 0. When `mode` is 1 they are ignored and only the register bits decide. All control inputs are asynchronous, so they pass through a two-flop synchronizer clocked by the reference clock.

Every output has its own four-state machine in the reference domain:
- `ST_STOPPED` goes to `ST_STARTING` when the request rises.
- `ST_STARTING` goes to `ST_RUNNING` once the gate is seen open.
- `ST_RUNNING` goes to `ST_STOPPING` when the request falls.
- `ST_STOPPING` goes to `ST_STOPPED` once the gate is seen closed.

The machine sets the arm level on a reference rising edge. A gate flop copies that level on the next falling edge of the target clock, and the output is the target clock ANDed with the gate. The gate's level is synchronized back into the reference domain and serves as the acknowledge that closes the `ST_STARTING` and `ST_STOPPING` states.

Top module: `clk_stop_gate`

## Requirements
- R1: A stopped output is held at logic 0 and shows no rising edge.
- R2: Every high pulse on every output lasts a full half period of its source clock, including the first pulse after a start and the last pulse before a stop.
- R3: A change of request takes effect only after it has passed two reference-clock rising edges of synchronization, followed by a falling edge of the target clock. A clock that is running when its enable drops therefore keeps toggling for at least the next reference period.
- R4: A processor or bus output runs only when its register enable bit is 1 and its group's stop permission is present.
- R5: With `mode`=0, `cpu_stop_n`=0 stops every processor output and leaves the bus outputs unchanged.
- R6: With `mode`=0, `pci_stop_n`=0 stops every bus output in `pci_clk_out` and leaves `free_clk_out` unchanged.
- R7: With `mode`=1, `cpu_stop_n` and `pci_stop_n` have no effect on any output.
- R8: `free_clk_out` runs exactly when `free_en` is 1, whatever `mode` and both stop pins are.
- R9: While `rst_n` is 0 every output is 0. After release, an output with a run request starts by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0: stop pins active, 1: stop pins ignored |
| cpu_stop_n | input | 1 | Active-low stop for the processor group |
| pci_stop_n | input | 1 | Active-low stop for the gated bus group |
| cpu_en | input | N_CPU | Register enable per processor output |
| pci_en | input | N_PCI | Register enable per bus output |
| free_en | input | 1 | Register enable for the free-running output |
| cpu_clk_in | input | N_CPU | Processor clocks to gate |
| pci_clk_in | input | N_PCI | Bus clocks to gate |
| cpu_clk_out | output | N_CPU | Gated processor clocks |
| pci_clk_out | output | N_PCI | Gated bus clocks |
| free_clk_out | output | 1 | Reference clock gated by `free_en` only |

## Verification
The assertions assume that every target clock comes from the same source as the reference clock. They also assume that a target's falling edge never lands on a reference rising edge. Without that, the arm level would be sampled in the same instant it changes. The stimulus meets this by aligning the processor clocks' rising edges, and the bus clocks' rising edges, with the reference rising edges. Control inputs change only on reference falling edges and are then held for dozens of periods, which gives every machine time to finish its handshake before the next change.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_STARTING = 2'd1,
        ST_RUNNING  = 2'd2,
        ST_STOPPING = 2'd3
    } gate_state_t;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cg_chan.sv
module cg_chan
    import clk_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic want,
    input  logic tgt_clk,
    output logic clk_out
);
    gate_state_t state_q, state_d;
    logic        arm;
    logic        gate_q;
    logic        gate_seen;

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (want)       state_d = ST_STARTING;
            ST_STARTING: if (gate_seen)  state_d = ST_RUNNING;
            ST_RUNNING:  if (!want)      state_d = ST_STOPPING;
            ST_STOPPING: if (!gate_seen) state_d = ST_STOPPED;
            default:                     state_d = ST_STOPPED;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        unique case (state_q)
            ST_STARTING, ST_RUNNING: arm = 1'b1;
            default:                 arm = 1'b0;
        endcase
    end

    // Gate moves only while the target clock is low
    always_ff @(negedge tgt_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= arm;
    end

    cg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (gate_q),
        .q     (gate_seen)
    );

    assign clk_out = tgt_clk & gate_q;

    assert_stopped_gate_closed_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |-> !gate_seen);

    assert_running_gate_open_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_RUNNING) |-> gate_seen);

    assert_no_direct_stop_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_RUNNING) |=> (state_q != ST_STOPPED));

    assert_no_direct_start_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |=> (state_q != ST_RUNNING));

    assert_idle_without_request_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !want) |=> (state_q == ST_STOPPED));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_CPU       = 4,
    parameter int N_PCI       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             free_en,
    input  logic [N_CPU-1:0] cpu_clk_in,
    input  logic [N_PCI-1:0] pci_clk_in,
    output logic [N_CPU-1:0] cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic             free_clk_out
);
    localparam int N_SYNC   = N_CPU + N_PCI + 4;
    localparam int IDX_MODE = N_CPU + N_PCI;
    localparam int IDX_CST  = IDX_MODE + 1;
    localparam int IDX_PST  = IDX_MODE + 2;
    localparam int IDX_FREE = IDX_MODE + 3;

    logic [N_SYNC-1:0] raw_ctl, syn_ctl;
    logic [N_CPU-1:0]  cpu_want;
    logic [N_PCI-1:0]  pci_want;
    logic              cpu_allow, pci_allow;

    assign raw_ctl = {free_en, pci_stop_n, cpu_stop_n, mode, pci_en, cpu_en};

    cg_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (raw_ctl),
        .q     (syn_ctl)
    );

    // Stop pins count only in mode 0
    assign cpu_allow = syn_ctl[IDX_MODE] | syn_ctl[IDX_CST];
    assign pci_allow = syn_ctl[IDX_MODE] | syn_ctl[IDX_PST];
    assign cpu_want  = syn_ctl[N_CPU-1:0] & {N_CPU{cpu_allow}};
    assign pci_want  = syn_ctl[N_CPU +: N_PCI] & {N_PCI{pci_allow}};

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        cg_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .want    (cpu_want[i]),
            .tgt_clk (cpu_clk_in[i]),
            .clk_out (cpu_clk_out[i])
        );
    end

    for (genvar j = 0; j < N_PCI; j++) begin : g_pci
        cg_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .want    (pci_want[j]),
            .tgt_clk (pci_clk_in[j]),
            .clk_out (pci_clk_out[j])
        );
    end

    cg_chan #(.SYNC_STAGES(SYNC_STAGES)) u_free (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .want    (syn_ctl[IDX_FREE]),
        .tgt_clk (ref_clk),
        .clk_out (free_clk_out)
    );

    assert_reset_outputs_low_R9: assert property (@(posedge ref_clk)
        !rst_n |-> (cpu_clk_out == '0 && pci_clk_out == '0 && !free_clk_out));
endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
    localparam int NC = 4;
    localparam int NP = 4;
    localparam int NT = NC + NP + 1;

    logic ref_clk = 1'b0;
    logic cpu_src = 1'b1;
    logic pci_src = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, free_en = 1'b1;
    logic [NC-1:0] cpu_en = '1;
    logic [NP-1:0] pci_en = '1;
    logic [NC-1:0] cpu_clk_out;
    logic [NP-1:0] pci_clk_out;
    logic          free_clk_out;
    logic [NT-1:0] all_out, all_prev;

    int n_tests = 0, n_fail = 0, width_err = 0, width_n = 0;
    int edges [NT];
    realtime t_rise [NT];
    bit done = 0;

    always #10 ref_clk = ~ref_clk;
    always #5  cpu_src = ~cpu_src;
    always #10 pci_src = ~pci_src;

    clk_stop_gate #(.N_CPU(NC), .N_PCI(NP)) u_dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .mode(mode),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_en(cpu_en), .pci_en(pci_en), .free_en(free_en),
        .cpu_clk_in({NC{cpu_src}}), .pci_clk_in({NP{pci_src}}),
        .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .free_clk_out(free_clk_out)
    );

    assign all_out = {free_clk_out, pci_clk_out, cpu_clk_out};

    function automatic real half_of(int idx);
        return (idx < NC) ? 5.0 : 10.0;
    endfunction

    function automatic int full_edges(int idx);
        return (idx < NC) ? 20 : 10;
    endfunction

    // Expected run state of one output (R4..R8)
    function automatic bit exp_run(int idx, bit m, bit cs, bit ps, bit en);
        if (idx < NC)           return en & (m | cs);
        else if (idx < NC + NP) return en & (m | ps);
        else                    return en;
    endfunction

    initial begin
        all_prev = '0;
        for (int k = 0; k < NT; k++) begin edges[k] = 0; t_rise[k] = 0.0; end
    end

    // Edge counting and pulse width monitor (R2)
    always @(all_out) begin
        for (int k = 0; k < NT; k++) begin
            if (all_out[k] && !all_prev[k]) begin
                t_rise[k] = $realtime;
                edges[k]  = edges[k] + 1;
            end else if (!all_out[k] && all_prev[k]) begin
                width_n = width_n + 1;
                if ((($realtime - t_rise[k]) - half_of(k)) > 0.01 ||
                    (($realtime - t_rise[k]) - half_of(k)) < -0.01) begin
                    width_err = width_err + 1;
                    $display("FAIL R2 output %0d pulse width actual %0.3f expected %0.3f",
                             k, $realtime - t_rise[k], half_of(k));
                end
            end
        end
        all_prev = all_out;
    end

    task automatic check(bit ok, string req, int idx, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s output %0d actual %0d expected %0d", req, idx, act, exp);
        end
    endtask

    task automatic apply_and_check(bit m, bit cs, bit ps, logic [NC-1:0] ce,
                                   logic [NP-1:0] pe, bit fe);
        int snap [NT];
        @(negedge ref_clk);
        mode = m; cpu_stop_n = cs; pci_stop_n = ps; cpu_en = ce; pci_en = pe; free_en = fe;
        repeat (24) @(negedge ref_clk);
        #1;
        for (int k = 0; k < NT; k++) snap[k] = edges[k];
        #200;
        for (int k = 0; k < NT; k++) begin
            bit en, run;
            string req;
            int got;
            en  = (k < NC) ? ce[k] : (k < NC + NP) ? pe[k-NC] : fe;
            run = exp_run(k, m, cs, ps, en);
            got = edges[k] - snap[k];
            if (k >= NC + NP)                  req = "R8";
            else if (!en)                      req = "R4";
            else if (k < NC && !cs)            req = m ? "R7" : "R5";
            else if (k >= NC && !ps)           req = m ? "R7" : "R6";
            else                               req = "R4";
            check(got == (run ? full_edges(k) : 0), req, k, got, run ? full_edges(k) : 0);
            if (!run) check(all_out[k] == 1'b0, "R1", k, int'(all_out[k]), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R9: outputs low while reset is held
        repeat (4) begin
            @(negedge ref_clk); #3;
            check(all_out == '0, "R9", -1, int'(all_out), 0);
        end
        @(negedge ref_clk); rst_n = 1'b1;
        // R9: starts by itself after release
        apply_and_check(1, 1, 1, '1, '1, 1);
        // R7: stop pins ignored in mode 1
        apply_and_check(1, 0, 0, '1, '1, 1);
        // R5: processor stop in mode 0
        apply_and_check(0, 0, 1, '1, '1, 1);
        // R6: bus stop leaves the free output alone
        apply_and_check(0, 1, 0, '1, '1, 1);
        // R8: free output only follows its own bit
        apply_and_check(0, 0, 0, '1, '1, 0);
        apply_and_check(0, 0, 0, '0, '0, 1);
        // R4: alternating enables
        apply_and_check(0, 1, 1, 4'b0101, 4'b1010, 1);
        apply_and_check(1, 1, 1, '1, '1, 1);
        // R3: a disable does not act within the next reference period
        begin
            int snap0;
            @(negedge ref_clk);
            cpu_en = '0;
            #1; snap0 = edges[0];
            #20;
            check(edges[0] - snap0 == 2, "R3", 0, edges[0] - snap0, 2);
        end
        // Random mix
        for (int it = 0; it < 40; it++) begin
            apply_and_check(1'($urandom), 1'($urandom), 1'($urandom),
                            NC'($urandom), NP'($urandom), 1'($urandom));
        end
        // R2: pulse widths over the whole run
        check(width_err == 0 && width_n > 100, "R2", -1, width_err, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule